// File: doc/BRIEF.md
# Cumulative Pulse Width Capture Timer

This block is one timer channel that totals how long an input signal spends in its active level, summed over many pulses. A mode input picks the polarity. With high-width measurement a rising edge begins an interval and a falling edge ends it. With low-width measurement the falling edge begins the interval and the rising edge ends it. The counter advances only on cycles where a count-enable input is high. That input normally comes from a prescaler outside the block.

Software arms the channel with a one-cycle start strobe and disarms it with a one-cycle stop strobe. After arming, the counter clears on the first start edge and then counts. Each end-of-interval edge copies the counter into a capture register and raises a one-cycle interrupt. The counter is not cleared between pulses. It pauses at the captured value plus one and continues from there on the next start edge, so every capture holds a running total. The live count, the capture value, the enable flag and a wrap flag can be read at any time.

Top module: `accum_width_timer`

## Requirements
- R1: After reset, `enabled`, `overflow` and `irq` are 0, and `count` and `capture` are 0.
- R2: A start strobe sets `enabled` on the next clock edge and clears `overflow`. `count` keeps its value until the first start edge is seen. That edge sets `count` to 0 without adding a step. After that, `count` rises by one on each clock where `cntEn` is 1 and is unchanged where `cntEn` is 0.
- R3: With `measLow` = 0 the start edge is rising and the stop edge is falling. With `measLow` = 1 the start edge is falling and the stop edge is rising.
- R4: On a stop edge while counting, `capture` takes the value `count` held in that cycle, and `irq` is high for exactly one cycle, in the same cycle that `capture` updates.
- R5: After a capture, `count` equals `capture` + 1 (modulo 2^WIDTH) and holds that value until the next start edge.
- R6: A later start edge resumes counting from the held value without clearing it. Each capture is therefore the total of all active widths since arming, minus one.
- R7: When `count` steps from all-ones to 0, `overflow` goes to 1 and stays set until the next start strobe.
- R8: A stop strobe clears `enabled` and freezes `count` at its current value. If start and stop strobes arrive in the same cycle, the stop strobe wins.
- R9: While the channel is disabled, input edges have no effect: `count`, `capture` and `irq` do not change.
- R10: An edge on `sigIn` takes effect on the third rising clock edge after the input changes: two edges to synchronize it and one to act on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startTrig | input | 1 | One-cycle arm strobe |
| stopTrig | input | 1 | One-cycle disarm strobe, wins over startTrig |
| measLow | input | 1 | 0: measure high time, 1: measure low time |
| cntEn | input | 1 | Count enable from an outside prescaler |
| sigIn | input | 1 | Asynchronous signal to be measured |
| enabled | output | 1 | Channel armed flag |
| overflow | output | 1 | Counter wrapped since the last start strobe |
| count | output | WIDTH | Live counter |
| capture | output | WIDTH | Last captured running total |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
Each input change reaches the control logic after two synchronizer edges, and the third edge acts on it. A pulse whose active level lasts N clocks with `cntEn` held high therefore adds N to the total, and the capture is due three edges after the closing input change. Strobes take effect on the first edge after they are driven. The driver predicts each capture and pushes it into a queue when it ends a pulse. The monitor checks `irq`, `capture` and `count` at the falling clock edge that follows each capture. Hold, freeze and wrap checks are made several cycles after the synchronizer has settled.

// File: rtl/awt_pkg.sv
package awt_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2,
    ST_PAUSE = 2'd3
  } chState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capture;
    logic clrOvf;
  } awtStrobe_t;

endpackage

// File: rtl/awt_edge_sync.sv
module awt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  input  logic measLow,
  output logic startEdge,
  output logic stopEdge
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic riseDet;
  logic fallDet;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sigIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[TOP];
  end

  assign riseDet   = syncQ[TOP] & ~prevQ;
  assign fallDet   = ~syncQ[TOP] & prevQ;
  assign startEdge = measLow ? fallDet : riseDet;
  assign stopEdge  = measLow ? riseDet : fallDet;

  // R3: a start edge and a stop edge never occur in the same cycle
  p_edges_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(startEdge && stopEdge));

endmodule

// File: rtl/awt_ctrl.sv
module awt_ctrl
  import awt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startTrig,
  input  logic       stopTrig,
  input  logic       cntEn,
  input  logic       startEdge,
  input  logic       stopEdge,
  output awtStrobe_t strobe,
  output logic       enabled
);
  chState_t state, nxtState;

  always_comb begin
    nxtState = state;
    strobe   = '0;
    if (stopTrig) begin
      nxtState = ST_OFF;
    end else if (startTrig) begin
      nxtState      = ST_ARM;
      strobe.clrOvf = 1'b1;
    end else begin
      unique case (state)
        ST_ARM: begin
          if (startEdge) begin
            nxtState      = ST_RUN;
            strobe.clrCnt = 1'b1;
          end
        end
        ST_RUN: begin
          if (stopEdge) begin
            nxtState       = ST_PAUSE;
            strobe.capture = 1'b1;
          end else if (cntEn) begin
            strobe.incCnt = 1'b1;
          end
        end
        ST_PAUSE: begin
          if (startEdge) nxtState = ST_RUN;
        end
        default: nxtState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxtState;
  end

  assign enabled = (state != ST_OFF);

  // R8: the stop strobe always disarms, even with a start strobe alongside
  p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopTrig |=> !enabled);

  // R2: a lone start strobe leaves the channel waiting for its first edge
  p_arm_waits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startTrig && !stopTrig) |=> (state == ST_ARM));

  // R9: a disarmed channel emits no datapath strobes
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !startTrig) |-> (strobe.clrCnt == 1'b0 && strobe.incCnt == 1'b0 && strobe.capture == 1'b0));

endmodule

// File: rtl/awt_datapath.sv
module awt_datapath
  import awt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  awtStrobe_t       strobe,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] capReg,
  output logic             irq,
  output logic             overflow
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic stepCnt;
  logic atMax;

  assign stepCnt = strobe.capture | strobe.incCnt;
  assign atMax   = (cnt == ALL_ONES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      capReg   <= '0;
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      irq <= strobe.capture;
      if (strobe.clrCnt)  cnt <= '0;
      else if (stepCnt)   cnt <= cnt + ONE;
      if (strobe.capture) capReg <= cnt;
      if (strobe.clrOvf)              overflow <= 1'b0;
      else if (stepCnt && atMax)      overflow <= 1'b1;
    end
  end

  // R4: the interrupt lasts one cycle
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4: the captured value is the count from the capture cycle
  p_cap_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (capReg == $past(cnt)));

  // R5: the count holds in the cycle after a capture
  p_hold_after_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> $stable(cnt));

  // R7: a start strobe clears the wrap flag
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrOvf |=> !overflow);

endmodule

// File: rtl/accum_width_timer.sv
module accum_width_timer
  import awt_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startTrig,
  input  logic             stopTrig,
  input  logic             measLow,
  input  logic             cntEn,
  input  logic             sigIn,
  output logic             enabled,
  output logic             overflow,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capture,
  output logic             irq
);
  awtStrobe_t strobe;
  logic       startEdge;
  logic       stopEdge;

  awt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk       (clk),
    .rstN      (rstN),
    .sigIn     (sigIn),
    .measLow   (measLow),
    .startEdge (startEdge),
    .stopEdge  (stopEdge)
  );

  awt_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startTrig (startTrig),
    .stopTrig  (stopTrig),
    .cntEn     (cntEn),
    .startEdge (startEdge),
    .stopEdge  (stopEdge),
    .strobe    (strobe),
    .enabled   (enabled)
  );

  awt_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cnt      (count),
    .capReg   (capture),
    .irq      (irq),
    .overflow (overflow)
  );

  // R9: a disarmed channel keeps its count
  p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> $stable(count));

endmodule

// File: tb/test_accum_width_timer.sv
module test_accum_width_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startTrig = 1'b0;
  logic stopTrig = 1'b0;
  logic measLow = 1'b0;
  logic cntEn = 1'b1;
  logic sigIn = 1'b0;
  logic enabled, overflow, irq;
  logic [W-1:0] count, capture;

  int checks = 0;
  int failures = 0;
  int expTotal = 0;
  bit freshArm = 1'b0;
  bit done = 1'b0;
  int expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_width_timer #(.WIDTH(W)) i_accum_width_timer (
    .clk(clk), .rstN(rstN), .startTrig(startTrig), .stopTrig(stopTrig),
    .measLow(measLow), .cntEn(cntEn), .sigIn(sigIn), .enabled(enabled),
    .overflow(overflow), .count(count), .capture(capture), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic trigStart();
    @(negedge clk) startTrig = 1'b1;
    @(negedge clk) startTrig = 1'b0;
    freshArm = 1'b1;
  endtask

  task automatic trigStop();
    @(negedge clk) stopTrig = 1'b1;
    @(negedge clk) stopTrig = 1'b0;
  endtask

  // one active pulse of 'width' clocks; predicts the capture (R6, R10)
  task automatic pulse(input int width, input bit en);
    int base;
    int cap;
    @(negedge clk);
    cntEn = en;
    sigIn = ~measLow;
    repeat (width) @(negedge clk);
    sigIn = measLow;
    base = freshArm ? 0 : expTotal;
    freshArm = 1'b0;
    cap = (base + (en ? width - 1 : 0)) & MASK;
    expQ.push_back(cap);
    expTotal = (cap + 1) & MASK;
    repeat (6) @(negedge clk);
    check(count == W'(expTotal), "R5 hold after capture", int'(count), expTotal);
    cntEn = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && irq) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4/R9 unexpected irq", int'(capture), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(capture == W'(e), "R4/R6 capture total", int'(capture), e);
        check(count == W'((e + 1) & MASK), "R5 count is capture+1", int'(count), (e + 1) & MASK);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(!enabled && !overflow && !irq, "R1 flags after reset", {enabled, overflow, irq}, 0);
    check(count == 0 && capture == 0, "R1 counters after reset", int'(count), 0);

    // R2: arm, count waits for first start edge
    trigStart();
    check(enabled == 1'b1, "R2 enable set", enabled, 1);
    repeat (4) @(negedge clk);
    check(count == 0, "R2 count idle before edge", int'(count), 0);

    // R3 high-width, R6 cumulative, R2 cntEn gating
    pulse(10, 1'b1);
    pulse(7, 1'b1);
    pulse(5, 1'b0);
    check(overflow == 1'b0, "R7 no wrap yet", overflow, 0);

    // R8 stop, R9 edges ignored while off
    trigStop();
    check(enabled == 1'b0, "R8 stop clears enable", enabled, 1'b0);
    held = int'(count);
    @(negedge clk) sigIn = 1'b1;
    repeat (8) @(negedge clk);
    sigIn = 1'b0;
    repeat (8) @(negedge clk);
    check(count == W'(held), "R9 count unchanged while off", int'(count), held);
    check(capture == W'((held - 1) & MASK), "R9 capture unchanged while off", int'(capture), (held - 1) & MASK);

    // R3 low-width mode; R2 count keeps value after arming
    sigIn = 1'b1;
    repeat (5) @(negedge clk);
    measLow = 1'b1;
    trigStart();
    repeat (3) @(negedge clk);
    check(count == W'(held), "R2 count kept until first edge", int'(count), held);
    pulse(12, 1'b1);
    pulse(4, 1'b1);

    // R8 stop wins over start, mid-count
    @(negedge clk) sigIn = 1'b0;
    repeat (10) @(negedge clk);
    startTrig = 1'b1;
    stopTrig = 1'b1;
    @(negedge clk);
    startTrig = 1'b0;
    stopTrig = 1'b0;
    check(enabled == 1'b0, "R8 stop has priority", enabled, 0);
    held = int'(count);
    repeat (5) @(negedge clk);
    check(count == W'(held), "R8 count frozen", int'(count), held);
    sigIn = 1'b1;
    repeat (6) @(negedge clk);
    check(count == W'(held), "R9 stop edge ignored while off", int'(count), held);

    // R7 wrap and flag clear
    sigIn = 1'b0;
    repeat (5) @(negedge clk);
    measLow = 1'b0;
    trigStart();
    check(overflow == 1'b0, "R7 flag clear after start", overflow, 0);
    pulse(300, 1'b1);
    check(overflow == 1'b1, "R7 flag set on wrap", overflow, 1);
    trigStart();
    check(overflow == 1'b0, "R7 start clears flag", overflow, 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R4 all captures seen", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule